// File: doc/BRIEF.md
# Configurable Logic Cluster Model

This block is a soft model of one programmable logic cluster. The cluster has two slices. Each slice has two four-input lookup elements, two storage elements and one wide-function multiplexer. A further wide multiplexer joins the two slices. Each lookup element can act as a logic function, as a 16x1 RAM or as a 16-bit shift register. Each storage element can act as a flip-flop or as a transparent latch. Its set/reset can be synchronous or asynchronous, and its clock and set/reset inputs can each be used true or inverted.

All behaviour comes from a 96-bit volatile configuration. The configuration is shifted in serially after reset, before the cluster is used. Until loading completes, every user output is held at 0. Element j (j = 2*slice + element-in-slice) takes its lookup address from `lut_in[4j+3:4j]`, with bit 4j as address bit 0. It drives `lut_out[j]` and `q_out[j]` and uses `se_sr[j]` as its set/reset input.

Top module: `lcl_cluster`

## Requirements
- R1: While `cfg_shift_en` is high, each rising edge shifts `cfg_shift_din` into the configuration, and the first bit ends at index 0 once all 96 bits are in. `cfg_done` rises on the edge after the one that takes the 96th bit and stays high until reset; afterwards `cfg_shift_en` has no effect. Layout for slice s and element e:
  - lookup table at [48s+18e+15 : 48s+18e];
  - lookup mode at [48s+18e+17 : 48s+18e+16];
  - storage options at [48s+36+6e+5 : 48s+36+6e].
- R2: While reset is active, and until `cfg_done` is high, `lut_out`, `wide5_out`, `wide6_out` and `q_out` are all 0.
- R3: In logic mode (mode 00, and also mode 11), `lut_out[j]` equals table bit `lut_in[4j+3:4j]`. `mem_we` does not change the table.
- R4: In RAM mode (mode 01), the loaded table is the initial content. A rising edge with `mem_we` high writes `mem_din` at the current address. The read is combinational from the current address.
- R5: In shift mode (mode 10), each rising edge with `mem_we` high shifts the content up one place and puts `mem_din` in bit 0. The output is the bit selected by the current address.
- R6: `wide5_out[s]` equals the slice's element-1 lookup output when `wide5_sel[s]` is 1, and its element-0 lookup output when it is 0.
- R7: `wide6_out` equals `wide5_out[1]` when `wide6_sel` is 1, and `wide5_out[0]` when it is 0.
- R8: With storage bit 0 = 0 (flip-flop), `q_out[j]` takes D on the active clock edge when `se_ce` is 1 and holds when `se_ce` is 0. Storage bit 2 = 1 makes the falling edge active.
- R9: With storage bit 0 = 1 (latch), `q_out[j]` follows D while the gate (clk, inverted by storage bit 2) is high and `se_ce` is 1. It holds while the gate is low.
- R10: With storage bit 1 = 1 (synchronous), an active set/reset forces `q_out[j]` to storage bit 4 on the next active edge, even when `se_ce` is 0. It has no effect before that edge.
- R11: With storage bit 1 = 0 (asynchronous), an active set/reset forces `q_out[j]` to storage bit 4 at once, without a clock edge.
- R12: Storage bit 3 = 1 makes `se_sr[j]` active-low. A high input is then inactive.
- R13: Storage bit 5 picks D. When 0, D is the element's own lookup output. When 1, element 0 of a slice takes that slice's `wide5_out` and element 1 takes `wide6_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_en | input | 1 | Configuration shift enable |
| cfg_shift_din | input | 1 | Configuration serial data |
| cfg_done | output | 1 | Configuration complete |
| lut_in | input | 16 | Four address bits per lookup element |
| mem_din | input | 1 | RAM write / shift-in data, shared by all elements |
| mem_we | input | 1 | RAM write / shift enable, shared by all elements |
| wide5_sel | input | 2 | Per-slice wide mux select |
| wide6_sel | input | 1 | Cross-slice wide mux select |
| se_ce | input | 1 | Storage clock enable |
| se_sr | input | 4 | Per-element set/reset |
| lut_out | output | 4 | Lookup element outputs |
| wide5_out | output | 2 | Per-slice wide mux outputs |
| wide6_out | output | 1 | Cross-slice wide mux output |
| q_out | output | 4 | Storage element outputs |

## Verification
The hardest case to reach is the falling-edge flip-flop fed from the cross-slice multiplexer. Its D depends on a lookup address, two mux selects and a table that earlier RAM and shift writes have already changed. The bench keeps its own model of every element's contents and updates it on each write or shift. Before a storage check, it searches that model for an address that yields the wanted D. It changes D just after a rising edge, confirms the rising edge did not capture it, and then checks the capture after the falling edge. The asynchronous and active-low set/reset cases are reached the same way: the bench first drives a known D into the element, then applies the set/reset between clock edges.

// File: rtl/lcl_pkg.sv
package lcl_pkg;
  localparam int LUT_K       = 4;
  localparam int LUT_DEPTH   = 1 << LUT_K;
  localparam int MODE_W      = 2;
  localparam int LUT_CFG_W   = LUT_DEPTH + MODE_W;
  localparam int SE_CFG_W    = 6;
  localparam int ELEMS       = 2;
  localparam int SLICES      = 2;
  localparam int SLICE_CFG_W = ELEMS * (LUT_CFG_W + SE_CFG_W);
  localparam int CFG_W       = SLICES * SLICE_CFG_W;
  localparam int NUM_ELEM    = SLICES * ELEMS;

  typedef enum logic [MODE_W-1:0] {
    LM_LOGIC     = 2'b00,
    LM_RAM       = 2'b01,
    LM_SHIFT     = 2'b10,
    LM_LOGIC_ALT = 2'b11
  } lut_mode_e;

  typedef struct packed {
    logic dsel;
    logic srval;
    logic sr_inv;
    logic clk_inv;
    logic sync_sr;
    logic latch;
  } se_cfg_t;
endpackage

// File: rtl/lcl_rst_sync.sv
module lcl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lcl_cfg_chain.sv
module lcl_cfg_chain #(
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_din,
  output logic [WIDTH-1:0] cfg,
  output logic             done
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] bits_q, bits_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             full;

  assign full = (cnt_q == CNT_W'(WIDTH));

  always_comb begin
    bits_d = bits_q;
    cnt_d  = cnt_q;
    if (shift_en && !full) begin
      bits_d = {shift_din, bits_q[WIDTH-1:1]};
      cnt_d  = cnt_q + 1'b1;
    end
    done_d = full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign cfg  = bits_q;
  assign done = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(bits_q)); // R1
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !full) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
endmodule

// File: rtl/lcl_lut.sv
module lcl_lut
  import lcl_pkg::*;
#(
  parameter int K     = LUT_K,
  parameter int DEPTH = 1 << K
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DEPTH-1:0] init,
  input  lut_mode_e        mode,
  input  logic [K-1:0]     addr,
  input  logic             din,
  input  logic             we,
  output logic             dout
);
  logic [DEPTH-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    if (!en) begin
      mem_d = init;
    end else if (we && mode == LM_RAM) begin
      mem_d[addr] = din;
    end else if (we && mode == LM_SHIFT) begin
      mem_d = {mem_q[DEPTH-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end

  assign dout = mem_q[addr];

  AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == LM_RAM && we) |=> (mem_q[$past(addr)] == $past(din))); // R4
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == LM_SHIFT && we) |=> (mem_q == {$past(mem_q[DEPTH-2:0]), $past(din)})); // R5
  AST_LOGIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (mode == LM_LOGIC || mode == LM_LOGIC_ALT)) |-> $stable(mem_q)); // R3
endmodule

// File: rtl/lcl_se.sv
module lcl_se
  import lcl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  se_cfg_t cfg,
  input  logic    d,
  input  logic    ce,
  input  logic    sr,
  output logic    q
);
  logic gate;
  logic sr_act;
  logic sr_async;
  logic ff_q, ff_d;
  logic lat_q;

  assign gate     = clk ^ cfg.clk_inv;
  assign sr_act   = sr ^ cfg.sr_inv;
  assign sr_async = sr_act & ~cfg.sync_sr & en;

  always_comb begin
    ff_d = ff_q;
    if (en) begin
      if (sr_act)  ff_d = cfg.srval;
      else if (ce) ff_d = d;
    end
  end

  always_ff @(posedge gate or posedge sr_async or negedge rst_n) begin
    if (!rst_n)        ff_q <= 1'b0;
    else if (sr_async) ff_q <= cfg.srval;
    else               ff_q <= ff_d;
  end

  always_latch begin
    if (!rst_n)
      lat_q <= 1'b0;
    else if (sr_async)
      lat_q <= cfg.srval;
    else if (gate && en && (sr_act || ce))
      lat_q <= sr_act ? cfg.srval : d;
  end

  assign q = cfg.latch ? lat_q : ff_q;

  AST_SYNC_SR: assert property (@(posedge gate) disable iff (!rst_n)
    (en && !cfg.latch && cfg.sync_sr && sr_act) |=> (q == cfg.srval)); // R10
  AST_FF_CAPTURE: assert property (@(posedge gate) disable iff (!rst_n)
    (en && !cfg.latch && cfg.sync_sr && !sr_act && ce) |=> (q == $past(d))); // R8
  AST_ASYNC_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg.sync_sr && sr_act) |-> (q == cfg.srval)); // R11
endmodule

// File: rtl/lcl_slice.sv
module lcl_slice
  import lcl_pkg::*;
#(
  parameter int K  = LUT_K,
  parameter int NE = ELEMS,
  parameter int CW = SLICE_CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cfg,
  input  logic [NE*K-1:0] lut_in,
  input  logic          mem_din,
  input  logic          mem_we,
  input  logic          wide5_sel,
  input  logic          wide6_in,
  input  logic          ce,
  input  logic [NE-1:0] sr,
  output logic [NE-1:0] lut_out,
  output logic          wide5_out,
  output logic [NE-1:0] q
);
  localparam int DEPTH = 1 << K;
  localparam int LCW   = DEPTH + MODE_W;
  localparam int SE_BASE = NE * LCW;

  logic wide5;

  assign wide5     = wide5_sel ? lut_out[1] : lut_out[0];
  assign wide5_out = wide5;

  for (genvar e = 0; e < NE; e++) begin : g_elem
    se_cfg_t   se_cfg;
    lut_mode_e mode;
    logic      se_d;

    assign mode   = lut_mode_e'(cfg[e*LCW + DEPTH +: MODE_W]);
    assign se_cfg = se_cfg_t'(cfg[SE_BASE + e*SE_CFG_W +: SE_CFG_W]);
    assign se_d   = se_cfg.dsel ? ((e == 0) ? wide5 : wide6_in) : lut_out[e];

    lcl_lut #(.K(K), .DEPTH(DEPTH)) i_lut (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .init (cfg[e*LCW +: DEPTH]),
      .mode (mode),
      .addr (lut_in[e*K +: K]),
      .din  (mem_din),
      .we   (mem_we),
      .dout (lut_out[e])
    );

    lcl_se i_se (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .cfg  (se_cfg),
      .d    (se_d),
      .ce   (ce),
      .sr   (sr[e]),
      .q    (q[e])
    );
  end
endmodule

// File: rtl/lcl_cluster.sv
module lcl_cluster
  import lcl_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_shift_en,
  input  logic                      cfg_shift_din,
  output logic                      cfg_done,
  input  logic [LUT_K*NUM_ELEM-1:0] lut_in,
  input  logic                      mem_din,
  input  logic                      mem_we,
  input  logic [SLICES-1:0]         wide5_sel,
  input  logic                      wide6_sel,
  input  logic                      se_ce,
  input  logic [NUM_ELEM-1:0]       se_sr,
  output logic [NUM_ELEM-1:0]       lut_out,
  output logic [SLICES-1:0]         wide5_out,
  output logic                      wide6_out,
  output logic [NUM_ELEM-1:0]       q_out
);
  localparam int SLICE_IN_W = LUT_K * ELEMS;

  logic                  rst_n_i;
  logic [CFG_W-1:0]      cfg;
  logic                  done;
  logic [NUM_ELEM-1:0]   lut_raw;
  logic [NUM_ELEM-1:0]   q_raw;
  logic [SLICES-1:0]     wide5_raw;
  logic                  wide6_raw;

  lcl_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_i)
  );

  lcl_cfg_chain #(.WIDTH(CFG_W)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .shift_en (cfg_shift_en),
    .shift_din(cfg_shift_din),
    .cfg      (cfg),
    .done     (done)
  );

  assign wide6_raw = wide6_sel ? wide5_raw[1] : wide5_raw[0];

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    lcl_slice #(.K(LUT_K), .NE(ELEMS), .CW(SLICE_CFG_W)) i_slice (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .en       (done),
      .cfg      (cfg[s*SLICE_CFG_W +: SLICE_CFG_W]),
      .lut_in   (lut_in[s*SLICE_IN_W +: SLICE_IN_W]),
      .mem_din  (mem_din),
      .mem_we   (mem_we),
      .wide5_sel(wide5_sel[s]),
      .wide6_in (wide6_raw),
      .ce       (se_ce),
      .sr       (se_sr[s*ELEMS +: ELEMS]),
      .lut_out  (lut_raw[s*ELEMS +: ELEMS]),
      .wide5_out(wide5_raw[s]),
      .q        (q_raw[s*ELEMS +: ELEMS])
    );
  end

  assign cfg_done  = done;
  assign lut_out   = lut_raw & {NUM_ELEM{done}};
  assign q_out     = q_raw & {NUM_ELEM{done}};
  assign wide5_out = wide5_raw & {SLICES{done}};
  assign wide6_out = wide6_raw & done;
endmodule

// File: tb/test_lcl_cluster.sv
module test_lcl_cluster;
  import lcl_pkg::*;

  localparam int NE = NUM_ELEM;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_shift_en, cfg_shift_din, mem_din, mem_we, wide6_sel, se_ce;
  logic [LUT_K*NE-1:0] lut_in;
  logic [SLICES-1:0]   wide5_sel;
  logic [NE-1:0]       se_sr;
  logic                cfg_done, wide6_out;
  logic [NE-1:0]       lut_out, q_out;
  logic [SLICES-1:0]   wide5_out;

  logic [CFG_W-1:0]     cfg;
  logic [LUT_DEPTH-1:0] m [NE];
  int n_chk = 0;
  int n_bad = 0;

  lcl_cluster i_lcl_cluster (
    .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_shift_din(cfg_shift_din),
    .cfg_done(cfg_done), .lut_in(lut_in), .mem_din(mem_din), .mem_we(mem_we),
    .wide5_sel(wide5_sel), .wide6_sel(wide6_sel), .se_ce(se_ce), .se_sr(se_sr),
    .lut_out(lut_out), .wide5_out(wide5_out), .wide6_out(wide6_out), .q_out(q_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic lv(input int j);
    return m[j][lut_in[4*j +: 4]];
  endfunction

  function automatic logic w5(input int s);
    return wide5_sel[s] ? lv(2*s+1) : lv(2*s);
  endfunction

  function automatic logic w6();
    return wide6_sel ? w5(1) : w5(0);
  endfunction

  function automatic logic [3:0] find_addr(input int j, input logic val);
    for (int a = 0; a < 16; a++) if (m[j][a] == val) return 4'(a);
    return 4'd0;
  endfunction

  task automatic put_lut(input int s, input int e, input logic [15:0] t, input logic [1:0] md);
    cfg[s*48 + e*18 +: 18] = {md, t};
    m[2*s+e] = t;
  endtask

  task automatic put_se(input int s, input int e, input logic [5:0] v);
    cfg[s*48 + 36 + e*6 +: 6] = v;
  endtask

  task automatic pulse_we(input logic din);
    @(negedge clk); mem_we = 1'b1; mem_din = din;
    @(negedge clk); mem_we = 1'b0;
    m[1][lut_in[7:4]] = din;
    m[2] = {m[2][14:0], din};
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_shift_en = 0; cfg_shift_din = 0; mem_din = 0; mem_we = 0;
    wide5_sel = '0; wide6_sel = 0; se_ce = 0; se_sr = 4'b1000; lut_in = '1;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 reset done", cfg_done, 0);
    chk("R2 reset lut_out", lut_out, 0);
    chk("R2 reset q_out", q_out, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_load();
    for (int i = 0; i < CFG_W; i++) begin
      @(negedge clk); cfg_shift_en = 1'b1; cfg_shift_din = cfg[i];
      if (i == 60) begin
        se_ce = 1'b1; #1;
        chk("R2 mid-load lut_out", lut_out, 0);
        chk("R2 mid-load q_out", q_out, 0);
        chk("R2 mid-load wide6_out", wide6_out, 0);
        chk("R1 done low mid-load", cfg_done, 0);
      end
    end
    @(negedge clk); cfg_shift_en = 1'b0; se_ce = 1'b0;
    chk("R1 done low right after last bit", cfg_done, 0);
    @(negedge clk);
    chk("R1 done one edge later", cfg_done, 1);
  endtask

  task automatic t_logic();
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); lut_in[3:0] = 4'(a); lut_in[15:12] = 4'(15 - a); #1;
      chk("R3 logic element 0", lut_out[0], m[0][a]);
      chk("R3 mode 11 element 3", lut_out[3], m[3][15-a]);
    end
  endtask

  task automatic t_cfg_ignore();
    @(negedge clk); cfg_shift_en = 1'b1; cfg_shift_din = 1'b1;
    repeat (20) @(negedge clk);
    cfg_shift_en = 1'b0;
    chk("R1 done stays high", cfg_done, 1);
    for (int a = 0; a < 16; a += 5) begin
      lut_in[3:0] = 4'(a); #1;
      chk("R1 table unchanged by late shifts", lut_out[0], m[0][a]);
    end
  endtask

  task automatic t_wide(input logic [15:0] pat);
    @(negedge clk); lut_in = pat;
    for (int c = 0; c < 8; c++) begin
      wide5_sel = 2'(c); wide6_sel = c[2]; #1;
      chk("R6 wide5 slice 0", wide5_out[0], w5(0));
      chk("R6 wide5 slice 1", wide5_out[1], w5(1));
      chk("R7 wide6", wide6_out, w6());
    end
  endtask

  task automatic t_ram();
    for (int a = 0; a < 16; a++) begin
      lut_in[7:4] = 4'(a); #1;
      chk("R4 RAM initial content", lut_out[1], m[1][a]);
    end
    lut_in[7:4] = 4'd3;  pulse_we(1'b0);
    lut_in[7:4] = 4'd12; pulse_we(1'b1);
    lut_in[7:4] = 4'd7;  pulse_we(1'b0);
    for (int a = 0; a < 16; a++) begin
      lut_in[7:4] = 4'(a); lut_in[3:0] = 4'(a); #1;
      chk("R4 RAM read after writes", lut_out[1], m[1][a]);
      chk("R3 logic ignores write enable", lut_out[0], m[0][a]);
    end
  endtask

  task automatic t_shift();
    logic [4:0] seq = 5'b10110;
    for (int k = 0; k < 5; k++) begin
      pulse_we(seq[k]);
      lut_in[11:8] = 4'd0; #1;
      chk("R5 shift tap 0", lut_out[2], m[2][0]);
      lut_in[11:8] = 4'(k + 1); #1;
      chk("R5 shift tap k", lut_out[2], m[2][k+1]);
    end
    for (int a = 0; a < 16; a++) begin
      lut_in[11:8] = 4'(a); #1;
      chk("R5 shift content", lut_out[2], m[2][a]);
    end
  endtask

  task automatic t_ff();
    wide5_sel = '0; wide6_sel = 1'b0;
    @(negedge clk); lut_in[3:0] = find_addr(0, 1'b1); se_ce = 1'b1;
    @(negedge clk); #1; chk("R8 flip-flop captures 1", q_out[0], 1);
    lut_in[3:0] = find_addr(0, 1'b0); se_ce = 1'b0;
    @(negedge clk); #1; chk("R8 flip-flop holds with ce low", q_out[0], 1);
    se_ce = 1'b1;
    @(negedge clk); #1; chk("R8 flip-flop captures 0", q_out[0], 0);
  endtask

  task automatic t_ffinv();
    wide5_sel = '0; wide6_sel = 1'b0; se_ce = 1'b1;
    @(posedge clk); #2; lut_in[3:0] = find_addr(0, 1'b0);
    @(negedge clk); #2; chk("R8 falling-edge capture 0", q_out[1], 0);
    lut_in[3:0] = find_addr(0, 1'b1);
    @(posedge clk); #2; chk("R8 rising edge ignored when inverted", q_out[1], 0);
    @(negedge clk); #2; chk("R13 falling-edge capture from wide6", q_out[1], 1);
  endtask

  task automatic t_latch();
    se_ce = 1'b1;
    @(posedge clk); #1; lut_in[11:8] = find_addr(2, 1'b0); #1;
    chk("R9 latch transparent 0", q_out[2], 0);
    lut_in[11:8] = find_addr(2, 1'b1); #1;
    chk("R9 latch follows while open", q_out[2], 1);
    @(negedge clk); #1; lut_in[11:8] = find_addr(2, 1'b0); #1;
    chk("R9 latch holds while closed", q_out[2], 1);
    @(posedge clk); #1; chk("R9 latch reopens", q_out[2], 0);
    @(negedge clk); #1; se_ce = 1'b0; lut_in[11:8] = find_addr(2, 1'b1);
    @(posedge clk); #1; chk("R9 latch blocked by ce low", q_out[2], 0);
    @(negedge clk); se_ce = 1'b1;
  endtask

  task automatic t_sync_sr();
    wide5_sel = '0; wide6_sel = 1'b0;
    @(negedge clk); lut_in[3:0] = find_addr(0, 1'b1); se_ce = 1'b1;
    @(negedge clk); #1; chk("R10 setup q=1", q_out[0], 1);
    se_ce = 1'b0; se_sr[0] = 1'b1; #1;
    chk("R10 sync set/reset waits for edge", q_out[0], 1);
    @(negedge clk); #1; chk("R10 sync set/reset with ce low", q_out[0], 0);
    se_sr[0] = 1'b0; se_ce = 1'b1;
  endtask

  task automatic t_async_sr();
    wide5_sel = '0; wide6_sel = 1'b0; se_ce = 1'b1;
    @(posedge clk); #2; lut_in[3:0] = find_addr(0, 1'b0);
    @(negedge clk); #2; chk("R11 setup q=0", q_out[1], 0);
    @(posedge clk); #2; se_sr[1] = 1'b1; #1;
    chk("R11 async set without edge", q_out[1], 1);
    @(negedge clk); #2; chk("R11 async set holds", q_out[1], 1);
    @(posedge clk); #2; se_sr[1] = 1'b0;
    @(negedge clk); #2; chk("R11 capture resumes", q_out[1], 0);
  endtask

  task automatic t_srinv();
    wide5_sel = '0; wide6_sel = 1'b0; se_ce = 1'b1;
    @(negedge clk); lut_in[3:0] = find_addr(0, 1'b1);
    @(negedge clk); #1; chk("R12 high input inactive", q_out[3], 1);
    se_sr[3] = 1'b0; #1;
    chk("R12 low input clears at once", q_out[3], 0);
    @(negedge clk); se_sr[3] = 1'b1;
    @(negedge clk); #1; chk("R12 released, captures again", q_out[3], 1);
  endtask

  task automatic t_dsel();
    se_ce = 1'b1; wide5_sel = 2'b01; wide6_sel = 1'b0;
    @(negedge clk); lut_in[3:0] = find_addr(0, 1'b0); lut_in[7:4] = find_addr(1, 1'b1);
    @(negedge clk); #1;
    chk("R13 element 0 uses own lookup", q_out[0], lv(0));
    chk("R13 element 3 uses wide6", q_out[3], w6());
    lut_in[3:0] = find_addr(0, 1'b1); lut_in[7:4] = find_addr(1, 1'b0);
    @(negedge clk); #1;
    chk("R13 element 0 own lookup swapped", q_out[0], lv(0));
    chk("R13 element 3 wide6 swapped", q_out[3], w6());
  endtask

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg = '0;
    put_lut(0, 0, 16'h6996, 2'b00); put_se(0, 0, 6'b000010);
    put_lut(0, 1, 16'h00FF, 2'b01); put_se(0, 1, 6'b110100);
    put_lut(1, 0, 16'h8001, 2'b10); put_se(1, 0, 6'b010011);
    put_lut(1, 1, 16'hF000, 2'b11); put_se(1, 1, 6'b101000);
    t_reset();
    t_load();
    t_logic();
    t_cfg_ignore();
    t_wide(16'h9C31);
    t_wide(16'h27E4);
    t_ram();
    t_shift();
    t_wide(16'h5A0F);
    t_ff();
    t_ffinv();
    t_latch();
    t_sync_sr();
    t_async_sr();
    t_srinv();
    t_dsel();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule